// File: doc/BRIEF.md
# Two-Bit-Per-Step Successive-Approximation Controller

This block is the digital sequencer of a successive-approximation converter that settles two result bits per clock instead of one. On each step it presents three trial codes to three external DAC/comparator pairs. The codes sit at the quarter, half and three-quarter points of the interval still being searched. It then takes the three comparator decisions back, reduces them to a bit pair and narrows the interval to one quarter. The analog DACs, the comparators and the sample-and-hold are outside the block.

The number of bit pairs N is chosen per conversion through a select input, from 1 up to an elaboration-time maximum NMAX. A 2N-bit result takes N steps. The result is left-justified in a 2·NMAX-bit word. A pulse on start launches a conversion. busy covers the steps and done marks the cycle in which the new result appears. A comparator pattern that is not a valid thermometer code is still resolved, and it raises a sticky error flag.

Top module: `sar2_conv`

## Requirements
- R1: While rst_n is low at a clock edge, result, busy, done and cmp_err become 0, and all three trial codes become 0.
- R2: During step s (s = 0 for the first busy cycle), trial_lo, trial_mid and trial_hi equal the bits already settled, followed by 01, 10 and 11 respectively in bit pair s, counting from the MSB, with every lower bit 0. While idle all three trial codes are 0.
- R3: cmp_hit[0], cmp_hit[1] and cmp_hit[2] are 1 when the input is at or above trial_lo, trial_mid and trial_hi respectively. The patterns 000, 001, 011 and 111 (written cmp_hit[2:0]) settle the bit pair as 00, 01, 10 and 11.
- R4: Any other comparator pattern settles the bit pair as its count of ones and sets cmp_err. cmp_err then stays 1 until reset.
- R5: busy is 1 for exactly N cycles after the edge that accepts start. done is 1 for exactly one cycle, which is the first cycle with busy back at 0.
- R6: The result has its 2N settled bits at the top of the word and zeros in the 2·(NMAX−N) bits below them. With an ideal comparator model it equals the input truncated to 2N bits.
- R7: start is ignored while busy is 1, including in the last step. No conversion follows the current one.
- R8: n_sel of 0 is treated as N = 1, and n_sel above NMAX is treated as N = NMAX.
- R9: result keeps its value from one done pulse to the next, whatever the comparator inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, taken only while idle |
| n_sel | input | $clog2(NMAX+1) | Number of bit pairs for the next conversion |
| cmp_hit | input | 3 | Comparator decisions for the low, middle and high trial codes |
| trial_lo | output | 2·NMAX | Quarter-point trial code |
| trial_mid | output | 2·NMAX | Half-point trial code |
| trial_hi | output | 2·NMAX | Three-quarter-point trial code |
| result | output | 2·NMAX | Last completed conversion, left-justified |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when result updates |
| cmp_err | output | 1 | Sticky flag for a non-thermometer comparator pattern |

## Verification
Two events can coincide: a start request and the final step, which latches the result and raises done. The bench holds start high through every busy cycle, including the last, and then checks three things. The busy count must still equal N. The result must be the one expected for the current input. busy must stay low afterwards, so the request was not queued into a new conversion. A second overlap puts a non-thermometer pattern on the comparators during the only step of a one-pair conversion. The bench checks that the same done cycle carries the popcount-resolved pair and a raised cmp_err.

// File: rtl/sar2_pkg.sv
// sar2_pkg: shared helpers for the two-bit-per-step converter controller.
// Assumes comparator bit k answers "input >= trial code k+1".
package sar2_pkg;

    // Bit pair settled by a comparator pattern: its count of ones.
    function automatic logic [1:0] pair_of(input logic [2:0] hits);
        return 2'(hits[0]) + 2'(hits[1]) + 2'(hits[2]);
    endfunction

    // True when the pattern is not a thermometer code.
    function automatic logic not_thermo(input logic [2:0] hits);
        return !(hits == 3'b000 || hits == 3'b001 ||
                 hits == 3'b011 || hits == 3'b111);
    endfunction

endpackage

// File: rtl/sar2_decode.sv
// sar2_decode: turns three comparator decisions into a two-bit result
// digit and flags patterns that are not thermometer codes.
// Assumes nothing about timing; purely combinational.
module sar2_decode
    import sar2_pkg::*;
(
    input  logic [2:0] hits,
    output logic [1:0] pair,
    output logic       bad
);

    // Reduce the pattern to a digit and a validity flag.
    always_comb begin
        pair = pair_of(hits);
        bad  = not_thermo(hits);
    end

endmodule

// File: rtl/sar2_trial.sv
// sar2_trial: builds the three trial codes of the current step from the
// settled prefix and the position of the pair under test.
// Assumes acc holds zeros at and below the pair under test.
module sar2_trial #(
    parameter int NMAX = 4,
    localparam int RW  = 2 * NMAX,
    localparam int SHW = (RW > 2) ? $clog2(RW) : 1
) (
    input  logic           active,
    input  logic [SHW-1:0] shamt,
    input  logic [RW-1:0]  acc,
    output logic [RW-1:0]  code [3]
);

    for (genvar k = 0; k < 3; k++) begin : g_code
        // Trial k+1: prefix with the value k+1 placed in the pair slot.
        always_comb begin
            code[k] = active ? (acc | (RW'(k + 1) << shamt)) : '0;
        end
    end

endmodule

// File: rtl/sar2_ctrl.sv
// sar2_ctrl: sequences a conversion of N bit pairs, accumulates the
// settled digits, latches the result and keeps the sticky error flag.
// Assumes pair/bad come combinationally from the current comparators.
module sar2_ctrl #(
    parameter int NMAX = 4,
    localparam int RW  = 2 * NMAX,
    localparam int SW  = $clog2(NMAX + 1),
    localparam int SHW = (RW > 2) ? $clog2(RW) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [SW-1:0]  n_sel,
    input  logic [1:0]     pair,
    input  logic           bad,
    output logic           busy_q,
    output logic           done_q,
    output logic           err_q,
    output logic [SHW-1:0] shamt,
    output logic [RW-1:0]  acc_q,
    output logic [RW-1:0]  result_q
);

    logic [SW-1:0] step_q;
    logic [SW-1:0] n_q;
    logic [SW-1:0] n_eff;
    logic [RW-1:0] acc_nx;
    logic          last;

    // Clamp the requested pair count into 1..NMAX.
    always_comb begin
        if (n_sel == '0)               n_eff = SW'(1);
        else if (n_sel > SW'(NMAX))    n_eff = SW'(NMAX);
        else                           n_eff = n_sel;
    end

    // Position of the pair under test and the prefix after this step.
    always_comb begin
        shamt  = SHW'(RW - 2 - 2 * int'(step_q));
        acc_nx = acc_q | (RW'(pair) << shamt);
        last   = (step_q == n_q - SW'(1));
    end

    // Conversion sequencer, result latch and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            step_q   <= '0;
            n_q      <= SW'(1);
            acc_q    <= '0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    step_q <= '0;
                    n_q    <= n_eff;
                    acc_q  <= '0;
                end
            end else begin
                acc_q <= acc_nx;
                if (bad) err_q <= 1'b1;
                if (last) begin
                    busy_q   <= 1'b0;
                    done_q   <= 1'b1;
                    result_q <= acc_nx;
                end else begin
                    step_q <= step_q + SW'(1);
                end
            end
        end
    end

    // R5: done lasts one cycle and closes a busy period.
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));
    // R7: a conversion before its last step keeps running with its own N.
    p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last) |=> (busy_q && n_q == $past(n_q)));
    // R4: the error flag never clears on its own.
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R8: the latched pair count stays within range.
    p_n_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (n_q >= SW'(1) && n_q <= SW'(NMAX)));
    // R6: bits below the 2N settled ones are zero.
    p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((result_q << {n_q, 1'b0}) == RW'(0)));

endmodule

// File: rtl/sar2_conv.sv
// sar2_conv: top of the two-bit-per-step successive-approximation
// controller. Drives three trial codes, reads three comparators, and
// settles two result bits per clock.
// Assumes the external comparators answer within the same cycle.
module sar2_conv #(
    parameter int NMAX = 4,
    localparam int RW  = 2 * NMAX,
    localparam int SW  = $clog2(NMAX + 1),
    localparam int SHW = (RW > 2) ? $clog2(RW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] n_sel,
    input  logic [2:0]    cmp_hit,
    output logic [RW-1:0] trial_lo,
    output logic [RW-1:0] trial_mid,
    output logic [RW-1:0] trial_hi,
    output logic [RW-1:0] result,
    output logic          busy,
    output logic          done,
    output logic          cmp_err
);

    logic [1:0]     pair;
    logic           bad;
    logic [SHW-1:0] shamt;
    logic [RW-1:0]  acc;
    logic [RW-1:0]  code [3];

    sar2_decode u_dec (
        .hits (cmp_hit),
        .pair (pair),
        .bad  (bad)
    );

    sar2_ctrl #(.NMAX(NMAX)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .n_sel    (n_sel),
        .pair     (pair),
        .bad      (bad),
        .busy_q   (busy),
        .done_q   (done),
        .err_q    (cmp_err),
        .shamt    (shamt),
        .acc_q    (acc),
        .result_q (result)
    );

    sar2_trial #(.NMAX(NMAX)) u_trial (
        .active (busy),
        .shamt  (shamt),
        .acc    (acc),
        .code   (code)
    );

    // Route the generated trial codes to the ports.
    always_comb begin
        trial_lo  = code[0];
        trial_mid = code[1];
        trial_hi  = code[2];
    end

    // R2: trial codes are strictly ordered while converting.
    p_trial_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (trial_lo < trial_mid && trial_mid < trial_hi));
    // R2: trial codes rest at zero while idle.
    p_trial_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (trial_lo == '0 && trial_mid == '0 && trial_hi == '0));
    // R9: result only moves on a done cycle.
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable(result)));

endmodule

// File: tb/sar2_conv_tb_top.sv
// Directed bench for sar2_conv with an ideal comparator model.
module sar2_conv_tb_top;
    localparam int NMAX = 4;
    localparam int RW   = 2 * NMAX;
    localparam int SW   = $clog2(NMAX + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] n_sel = '0;
    logic [2:0]    cmp_hit;
    logic [RW-1:0] trial_lo, trial_mid, trial_hi, result;
    logic          busy, done, cmp_err;

    int   vin = 0;
    logic force_en = 1'b0;
    logic [2:0] force_pat = 3'b000;
    int   n_cmp = 0;
    int   n_bad = 0;

    always #5 clk = ~clk;

    // Comparator model: hit k when the input is at or above trial k+1.
    assign cmp_hit = force_en ? force_pat :
        {3{1'b1}} & {int'(trial_hi) <= vin, int'(trial_mid) <= vin,
                     int'(trial_lo) <= vin};

    sar2_conv #(.NMAX(NMAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .n_sel(n_sel),
        .cmp_hit(cmp_hit), .trial_lo(trial_lo), .trial_mid(trial_mid),
        .trial_hi(trial_hi), .result(result), .busy(busy), .done(done),
        .cmp_err(cmp_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One conversion; checks trials per step, busy length, done and result.
    task automatic run_conv(input int v, input int sel, input int ncyc,
                            input int exp_res, input bit hammer);
        vin = v;
        @(negedge clk); start = 1'b1; n_sel = SW'(sel);
        @(negedge clk); start = hammer;
        for (int cnt = 0; cnt < 64; cnt++) begin
            if (!busy) begin
                chk(cnt == ncyc, "R5 busy length", cnt, ncyc);
                break;
            end
            if (!force_en) begin
                int pre;
                int sh;
                sh  = RW - 2 * cnt;
                pre = (v >> sh) << sh;
                chk(int'(trial_lo) == pre + (1 << (sh - 2)), "R2 trial_lo", int'(trial_lo), pre + (1 << (sh - 2)));
                chk(int'(trial_mid) == pre + (2 << (sh - 2)), "R2 trial_mid", int'(trial_mid), pre + (2 << (sh - 2)));
                chk(int'(trial_hi) == pre + (3 << (sh - 2)), "R2 trial_hi", int'(trial_hi), pre + (3 << (sh - 2)));
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done == 1'b1, "R5 done at end", int'(done), 1);
        chk(int'(result) == exp_res, "R6 result", int'(result), exp_res);
        chk(trial_lo == '0 && trial_hi == '0, "R2 idle trials", int'(trial_hi), 0);
        @(negedge clk);
        chk(done == 1'b0, "R5 done single", int'(done), 0);
        chk(busy == 1'b0, "R7 no queued start", int'(busy), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(result == '0 && !busy && !done && !cmp_err, "R1 reset outputs", int'(result), 0);
        chk(trial_lo == '0 && trial_mid == '0 && trial_hi == '0, "R1 reset trials", int'(trial_mid), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_full_res();
        int vals[5] = '{0, 255, 128, 173, 63};
        foreach (vals[i]) run_conv(vals[i], NMAX, NMAX, vals[i], 1'b0);
    endtask

    task automatic t_partial_res();
        run_conv(173, 1, 1, 173 & 8'hC0, 1'b0);
        run_conv(173, 2, 2, 173 & 8'hF0, 1'b0);
        run_conv(94, 3, 3, 94 & 8'hFC, 1'b0);
    endtask

    task automatic t_clamp_r8();
        run_conv(201, 0, 1, 201 & 8'hC0, 1'b0);
        run_conv(201, 7, NMAX, 201, 1'b0);
    endtask

    task automatic t_start_ignored_r7();
        run_conv(77, 3, 3, 77 & 8'hFC, 1'b1);
        run_conv(230, NMAX, NMAX, 230, 1'b1);
    endtask

    task automatic t_thermo_r3();
        logic [2:0] pats[4] = '{3'b000, 3'b001, 3'b011, 3'b111};
        force_en = 1'b1;
        foreach (pats[i]) begin
            force_pat = pats[i];
            run_conv(0, 1, 1, i << 6, 1'b0);
            chk(cmp_err == 1'b0, "R3 valid pattern no error", int'(cmp_err), 0);
        end
        force_en = 1'b0;
    endtask

    task automatic t_bad_r4();
        force_en = 1'b1;
        force_pat = 3'b010;
        run_conv(0, 1, 1, 8'h40, 1'b0);
        chk(cmp_err == 1'b1, "R4 error set", int'(cmp_err), 1);
        force_pat = 3'b101;
        run_conv(0, 2, 2, 8'hA0, 1'b0);
        force_en = 1'b0;
        run_conv(19, NMAX, NMAX, 19, 1'b0);
        chk(cmp_err == 1'b1, "R4 error sticky", int'(cmp_err), 1);
        t_reset();
        chk(cmp_err == 1'b0, "R4 cleared by reset", int'(cmp_err), 0);
    endtask

    task automatic t_hold_r9();
        run_conv(150, NMAX, NMAX, 150, 1'b0);
        vin = 3;
        force_en = 1'b1;
        force_pat = 3'b111;
        repeat (5) @(negedge clk);
        chk(int'(result) == 150, "R9 result held", int'(result), 150);
        force_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_full_res();
        t_partial_res();
        t_clamp_r8();
        t_start_ignored_r7();
        t_thermo_r3();
        t_bad_r4();
        t_hold_r9();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule